// File: doc/BRIEF.md
# Copy-Based Out-of-Order Operation Scheduler

This block accepts one decoded operation per cycle in program order and lets operations start and finish out of order. It holds five operation slots (one integer slot, one load slot, one store slot and two floating-point slots), a table that records, for each architectural register, which slot will produce its next value, and a register file holding the committed values. Each slot copies its operand values at dispatch when they are already available, or records the number of the producing slot and picks the value up later from a single result bus.

When both operands of a slot are present it starts its fixed-latency execution stub. Finished slots compete for the result bus; the winner broadcasts its slot number and value, and every waiting slot, as well as an operation being dispatched in that cycle, takes the value. The register file is written only when the producer table still names the broadcasting slot, so a later write to the same register never has to wait and an older result never overwrites a newer one. A read port exposes any register's committed value and pending producer.

Top module: `tomasulo_sched`

## Requirements
- R1: After reset all slots are free (`fu_free` = 4'b1111), the result bus is idle, every producer tag reads 0 and register i holds the value i+1.
- R2: Slot numbers are tags: integer = 1, load = 2, store = 3, floating-point = 4 and 5; a floating-point operation takes slot 4 when it is free, otherwise slot 5. Class codes on `disp_class`: 0 integer, 1 load, 2 store, 3 floating-point.
- R3: Results: integer op 0 adds, op 1 subtracts (src1 - src2); floating-point op 0 multiplies (low DW bits), op 1 adds; a load returns (src1 + src2) XOR 16'hAAAA. With operands ready, the bus shows the result 3, 4 and 5 cycles after the dispatch edge for integer, load and floating-point operations.
- R4: `fu_free[c]` is low when no slot of class c can be taken; a dispatch in that cycle is dropped and changes no state.
- R5: A dispatch with a destination sets that register's producer tag to the allocated slot, replacing any older pending tag, and does not stall for it.
- R6: A source with tag 0 has its register value copied; otherwise the tag is copied and the slot takes the value when that tag appears on the bus, including when the bus carries it in the dispatch cycle itself.
- R7: On a broadcast the register file is written and the producer tag cleared only when the tag still names the broadcasting slot; otherwise both are left unchanged.
- R8: A store renames no register, never drives the bus, and frees its slot after it finishes.
- R9: An operation whose last missing operand is broadcast starts execution at that same edge: a dependent floating-point result appears 4 cycles after its producer's broadcast.
- R10: A slot broadcasting in the current cycle counts as free for dispatch in that cycle.
- R11: When several slots finish together the lowest slot number wins the bus; the others keep their results and broadcast in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Operation offered for dispatch |
| disp_class | input | 2 | Unit class of the operation |
| disp_op | input | 1 | Operation select within the class |
| disp_dst | input | RW | Destination register (unused for stores) |
| disp_src1 | input | RW | First source register |
| disp_src2 | input | RW | Second source register |
| fu_free | output | 4 | Per class: a slot can be taken this cycle |
| cdb_valid | output | 1 | Result bus carries a broadcast |
| cdb_tag | output | 3 | Broadcasting slot number |
| cdb_value | output | DW | Broadcast result |
| peek_addr | input | RW | Register to inspect |
| peek_value | output | DW | Committed value of that register |
| peek_tag | output | 3 | Pending producer of that register, 0 if none |

## Verification
The bench aims at an older floating-point result arriving after a younger integer write to the same register; a design that ignores the tag comparison at writeback would leave the stale product in the register file. It times a dependent operation against its producer's broadcast, which exposes a scheduler that waits one extra cycle before starting, and dispatches a consumer in the very cycle its producer broadcasts, where a missing dispatch-side snoop leaves the consumer waiting forever. It also finishes two slots on the same edge to catch a lost or misordered loser, and offers operations when a class is full and to the store slot to show nothing is renamed or broadcast by mistake.

// File: rtl/ts_pkg.sv
// Shared types and helpers for the copy-based scheduler.
// Assumes a fixed set of five slots in a fixed class order.
package ts_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_LD  = 2'd1,
        CLS_ST  = 2'd2,
        CLS_FP  = 2'd3
    } fu_class_e;

    localparam int NUM_RS = 5;
    localparam int TAG_W  = 3;

    // Class of slot index idx (tag = idx + 1).
    function automatic fu_class_e rs_class(input int idx);
        case (idx)
            0:       return CLS_ALU;
            1:       return CLS_LD;
            2:       return CLS_ST;
            default: return CLS_FP;
        endcase
    endfunction

    // Execution latency for a class.
    function automatic int rs_latency(input fu_class_e c, input int alu_lat,
                                      input int ld_lat, input int fp_lat);
        case (c)
            CLS_LD:  return ld_lat;
            CLS_FP:  return fp_lat;
            default: return alu_lat;
        endcase
    endfunction

endpackage

// File: rtl/ts_regmap.sv
// Register file plus producer-tag table.
// Three combinational read ports; one rename and one writeback per cycle.
// Assumes rename wins over a clear of the same entry in one cycle.
module ts_regmap
    import ts_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    rd_a_addr,
    output logic [DW-1:0]    rd_a_val,
    output logic [TAG_W-1:0] rd_a_tag,
    input  logic [RW-1:0]    rd_b_addr,
    output logic [DW-1:0]    rd_b_val,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic [RW-1:0]    rd_c_addr,
    output logic [DW-1:0]    rd_c_val,
    output logic [TAG_W-1:0] rd_c_tag,
    input  logic             ren_en,
    input  logic [RW-1:0]    ren_reg,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic             wb_en,
    input  logic [RW-1:0]    wb_reg,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic [DW-1:0]    wb_val
);

    logic [DW-1:0]    rf_q  [NREG];
    logic [TAG_W-1:0] map_q [NREG];

    // Read ports.
    assign rd_a_val = rf_q[rd_a_addr];
    assign rd_a_tag = map_q[rd_a_addr];
    assign rd_b_val = rf_q[rd_b_addr];
    assign rd_b_tag = map_q[rd_b_addr];
    assign rd_c_val = rf_q[rd_c_addr];
    assign rd_c_tag = map_q[rd_c_addr];

    // Reset to i+1, then rename and conditional writeback per entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                rf_q[i]  <= DW'(i + 1);
                map_q[i] <= '0;
            end else begin
                if (wb_en && wb_reg == RW'(i) && map_q[i] == wb_tag)
                    rf_q[i] <= wb_val;
                if (ren_en && ren_reg == RW'(i))
                    map_q[i] <= ren_tag;
                else if (wb_en && wb_reg == RW'(i) && map_q[i] == wb_tag)
                    map_q[i] <= '0;
            end
        end
    end

endmodule

// File: rtl/ts_station.sv
// One operation slot with its fixed-latency execution stub.
// Holds op, destination, two tags and two copied values; snoops the bus,
// starts when both tags are clear, holds its result until released.
// Assumes the bus never carries tag 0.
module ts_station
    import ts_pkg::*;
#(
    parameter int        DW   = 16,
    parameter int        RW   = 3,
    parameter fu_class_e KIND = CLS_ALU,
    parameter int        LAT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             alloc_op,
    input  logic [RW-1:0]    alloc_dst,
    input  logic [TAG_W-1:0] alloc_t1,
    input  logic [DW-1:0]    alloc_v1,
    input  logic [TAG_W-1:0] alloc_t2,
    input  logic [DW-1:0]    alloc_v2,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [DW-1:0]    cdb_value,
    input  logic             grant,
    output logic             busy,
    output logic             req,
    output logic             release_now,
    output logic [DW-1:0]    result,
    output logic [RW-1:0]    dst
);

    localparam int  CW    = $clog2(LAT + 1);
    localparam bit  IS_ST = (KIND == CLS_ST);

    logic             busy_q, issued_q, done_q, op_q;
    logic [CW-1:0]    cnt_q;
    logic [TAG_W-1:0] t1_q, t2_q;
    logic [DW-1:0]    v1_q, v2_q, res_q;
    logic [RW-1:0]    dst_q;
    logic             hit1, hit2, go;

    // Execution stub for this slot's class.
    function automatic logic [DW-1:0] compute(input logic op, input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
        case (KIND)
            CLS_ALU: return op ? a - b : a + b;
            CLS_LD:  return (a + b) ^ {(DW/2){2'b10}};
            CLS_FP:  return op ? a + b : DW'(a * b);
            default: return a;
        endcase
    endfunction

    // Bus matches and start condition.
    assign hit1 = cdb_valid && t1_q != '0 && t1_q == cdb_tag;
    assign hit2 = cdb_valid && t2_q != '0 && t2_q == cdb_tag;
    assign go   = busy_q && !issued_q && (t1_q == '0 || hit1) && (t2_q == '0 || hit2);

    assign busy        = busy_q;
    assign req         = busy_q && done_q && !IS_ST;
    assign release_now = busy_q && done_q && (IS_ST || grant);
    assign result      = res_q;
    assign dst         = dst_q;

    // Slot lifecycle: allocate, capture, start, count down, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            issued_q <= 1'b0;
            done_q   <= 1'b0;
            op_q     <= 1'b0;
            cnt_q    <= '0;
            t1_q     <= '0;
            t2_q     <= '0;
            v1_q     <= '0;
            v2_q     <= '0;
            res_q    <= '0;
            dst_q    <= '0;
        end else if (alloc) begin
            busy_q   <= 1'b1;
            issued_q <= 1'b0;
            done_q   <= 1'b0;
            op_q     <= alloc_op;
            dst_q    <= alloc_dst;
            t1_q     <= alloc_t1;
            v1_q     <= alloc_v1;
            t2_q     <= alloc_t2;
            v2_q     <= alloc_v2;
        end else if (release_now) begin
            busy_q   <= 1'b0;
            issued_q <= 1'b0;
            done_q   <= 1'b0;
        end else if (busy_q) begin
            if (hit1) begin
                t1_q <= '0;
                v1_q <= cdb_value;
            end
            if (hit2) begin
                t2_q <= '0;
                v2_q <= cdb_value;
            end
            if (go) begin
                issued_q <= 1'b1;
                cnt_q    <= CW'(LAT);
            end else if (issued_q && !done_q) begin
                if (cnt_q == CW'(1)) begin
                    done_q <= 1'b1;
                    res_q  <= compute(op_q, v1_q, v2_q);
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ts_fixed_arb.sv
// Fixed-priority arbiter: lowest index wins. Purely combinational.
module ts_fixed_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // Pick the lowest requesting index.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tomasulo_sched.sv
// Copy-based out-of-order scheduler top: dispatch, five slots, bus, regfile.
// Assumes in-order single dispatch per cycle; a dropped dispatch is retried
// by the source.
module tomasulo_sched
    import ts_pkg::*;
#(
    parameter int DW      = 16,
    parameter int NREG    = 8,
    parameter int ALU_LAT = 1,
    parameter int LD_LAT  = 2,
    parameter int FP_LAT  = 3,
    localparam int RW     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [1:0]       disp_class,
    input  logic             disp_op,
    input  logic [RW-1:0]    disp_dst,
    input  logic [RW-1:0]    disp_src1,
    input  logic [RW-1:0]    disp_src2,
    output logic [3:0]       fu_free,
    output logic             cdb_valid,
    output logic [TAG_W-1:0] cdb_tag,
    output logic [DW-1:0]    cdb_value,
    input  logic [RW-1:0]    peek_addr,
    output logic [DW-1:0]    peek_value,
    output logic [TAG_W-1:0] peek_tag
);

    logic [NUM_RS-1:0] rs_busy, rs_req, rs_rel, rs_grant, rs_alloc, avail;
    logic [DW-1:0]     rs_res [NUM_RS];
    logic [RW-1:0]     rs_dst [NUM_RS];
    logic [RW-1:0]     cdb_dst;
    logic [DW-1:0]     m1_val, m2_val, s1_val, s2_val;
    logic [TAG_W-1:0]  m1_tag, m2_tag, s1_tag, s2_tag;
    logic              accept;
    int                sel;

    // Slot availability per class, counting slots released this cycle.
    assign avail   = ~rs_busy | rs_rel;
    assign fu_free = {avail[3] | avail[4], avail[2], avail[1], avail[0]};
    assign accept  = disp_valid && fu_free[disp_class];

    // Slot selection: fixed per class, lowest free floating-point slot.
    always_comb begin
        case (fu_class_e'(disp_class))
            CLS_ALU: sel = 0;
            CLS_LD:  sel = 1;
            CLS_ST:  sel = 2;
            default: sel = avail[3] ? 3 : 4;
        endcase
        for (int i = 0; i < NUM_RS; i++)
            rs_alloc[i] = accept && sel == i;
    end

    // Source operands: tag or value, taking a same-cycle broadcast.
    always_comb begin
        s1_tag = m1_tag;
        s1_val = m1_val;
        if (m1_tag != '0) begin
            s1_val = '0;
            if (cdb_valid && cdb_tag == m1_tag) begin
                s1_tag = '0;
                s1_val = cdb_value;
            end
        end
        s2_tag = m2_tag;
        s2_val = m2_val;
        if (m2_tag != '0) begin
            s2_val = '0;
            if (cdb_valid && cdb_tag == m2_tag) begin
                s2_tag = '0;
                s2_val = cdb_value;
            end
        end
    end

    ts_regmap #(.DW(DW), .NREG(NREG)) u_regmap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (disp_src1),
        .rd_a_val  (m1_val),
        .rd_a_tag  (m1_tag),
        .rd_b_addr (disp_src2),
        .rd_b_val  (m2_val),
        .rd_b_tag  (m2_tag),
        .rd_c_addr (peek_addr),
        .rd_c_val  (peek_value),
        .rd_c_tag  (peek_tag),
        .ren_en    (accept && fu_class_e'(disp_class) != CLS_ST),
        .ren_reg   (disp_dst),
        .ren_tag   (TAG_W'(sel + 1)),
        .wb_en     (cdb_valid),
        .wb_reg    (cdb_dst),
        .wb_tag    (cdb_tag),
        .wb_val    (cdb_value)
    );

    for (genvar g = 0; g < NUM_RS; g++) begin : g_rs
        localparam fu_class_e K = rs_class(g);
        ts_station #(
            .DW   (DW),
            .RW   (RW),
            .KIND (K),
            .LAT  (rs_latency(K, ALU_LAT, LD_LAT, FP_LAT))
        ) u_rs (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (rs_alloc[g]),
            .alloc_op    (disp_op),
            .alloc_dst   (disp_dst),
            .alloc_t1    (s1_tag),
            .alloc_v1    (s1_val),
            .alloc_t2    (s2_tag),
            .alloc_v2    (s2_val),
            .cdb_valid   (cdb_valid),
            .cdb_tag     (cdb_tag),
            .cdb_value   (cdb_value),
            .grant       (rs_grant[g]),
            .busy        (rs_busy[g]),
            .req         (rs_req[g]),
            .release_now (rs_rel[g]),
            .result      (rs_res[g]),
            .dst         (rs_dst[g])
        );
    end

    ts_fixed_arb #(.N(NUM_RS)) u_arb (
        .req   (rs_req),
        .grant (rs_grant)
    );

    // Result bus mux from the granted slot.
    always_comb begin
        cdb_valid = |rs_grant;
        cdb_tag   = '0;
        cdb_value = '0;
        cdb_dst   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (rs_grant[i]) begin
                cdb_tag   = TAG_W'(i + 1);
                cdb_value = rs_res[i];
                cdb_dst   = rs_dst[i];
            end
        end
    end

endmodule

// File: rtl/ts_checker.sv
// Temporal checks on the scheduler, attached by bind.
module ts_checker
    import ts_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [NUM_RS-1:0] busy,
    input logic [NUM_RS-1:0] req,
    input logic [3:0]        fu_free,
    input logic              disp_valid,
    input logic [1:0]        disp_class
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (busy == '0 && !cdb_valid));  // R1

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != 3'd3 && cdb_tag >= 3'd1 && cdb_tag <= 3'd5));  // R8

    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy) <= $countones($past(busy)) + 1);  // R4

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> ((req & ((5'd1 << (cdb_tag - 3'd1)) - 5'd1)) == 5'd0));  // R11

    AST_LOSER_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && $countones(req) > 1) |=> cdb_valid);  // R11

    AST_BCAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !(disp_valid && fu_free[disp_class]))
        |=> !busy[3'($past(cdb_tag) - 3'd1)]);  // R10

endmodule

bind tomasulo_sched ts_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .busy       (rs_busy),
    .req        (rs_req),
    .fu_free    (fu_free),
    .disp_valid (disp_valid),
    .disp_class (disp_class)
);

// File: tb/tb_tomasulo_sched.sv
`timescale 1ns/1ps
module tb_tomasulo_sched;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid;
    logic [1:0]  disp_class;
    logic        disp_op;
    logic [2:0]  disp_dst, disp_src1, disp_src2;
    logic [3:0]  fu_free;
    logic        cdb_valid;
    logic [2:0]  cdb_tag;
    logic [15:0] cdb_value;
    logic [2:0]  peek_addr;
    logic [15:0] peek_value;
    logic [2:0]  peek_tag;

    int checks = 0;
    int errors = 0;
    logic [15:0] mrf [8];

    always #4 clk = ~clk;

    tomasulo_sched dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_valid (disp_valid),
        .disp_class (disp_class),
        .disp_op    (disp_op),
        .disp_dst   (disp_dst),
        .disp_src1  (disp_src1),
        .disp_src2  (disp_src2),
        .fu_free    (fu_free),
        .cdb_valid  (cdb_valid),
        .cdb_tag    (cdb_tag),
        .cdb_value  (cdb_value),
        .peek_addr  (peek_addr),
        .peek_value (peek_value),
        .peek_tag   (peek_tag)
    );

    // Stimulus table: class[11:10] op[9] dst[8:6] src1[5:3] src2[2:0]
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 1'b0, 3'd1, 3'd2, 3'd3},
        {2'd0, 1'b1, 3'd2, 3'd4, 3'd1},
        {2'd1, 1'b0, 3'd3, 3'd5, 3'd6},
        {2'd3, 1'b0, 3'd4, 3'd2, 3'd3},
        {2'd3, 1'b1, 3'd5, 3'd4, 3'd4},
        {2'd0, 1'b0, 3'd6, 3'd6, 3'd6},
        {2'd1, 1'b0, 3'd7, 3'd0, 3'd1},
        {2'd3, 1'b0, 3'd0, 3'd7, 3'd3}
    };

    function automatic logic [15:0] exp_res(input logic [1:0] c, input logic op,
                                            input logic [15:0] a, input logic [15:0] b);
        case (c)
            2'd0:    return op ? a - b : a + b;
            2'd1:    return (a + b) ^ 16'hAAAA;
            2'd3:    return op ? a + b : 16'(a * b);
            default: return 16'h0;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic op, input logic [2:0] d,
                         input logic [2:0] a, input logic [2:0] b);
        disp_valid = 1'b1;
        disp_class = c;
        disp_op    = op;
        disp_dst   = d;
        disp_src1  = a;
        disp_src2  = b;
    endtask

    task automatic idle();
        disp_valid = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v, output logic [2:0] t);
        peek_addr = a;
        #1;
        v = peek_value;
        t = peek_tag;
    endtask

    task automatic wait_bus(inout int n);
        while (!cdb_valid && n < 40) begin
            step();
            n++;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, e1, e2;
        logic [2:0]  t;
        int n, nb;
        rst_n = 1'b0;
        disp_valid = 1'b0;
        disp_class = '0;
        disp_op = 1'b0;
        disp_dst = '0;
        disp_src1 = '0;
        disp_src2 = '0;
        peek_addr = '0;
        for (int i = 0; i < 8; i++) mrf[i] = 16'(i + 1);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 fu_free", fu_free, 4'b1111);
        chk("R1 bus idle", cdb_valid, 1'b0);
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), v, t);
            chk("R1 reg value", v, mrf[i]);
            chk("R1 reg tag", t, 0);
        end

        // Table of single operations: R2 tags, R3 results and latency, R7 commit
        for (int k = 0; k < 8; k++) begin
            logic [11:0] w;
            int lat;
            w  = VEC[k];
            e1 = exp_res(w[11:10], w[9], mrf[w[5:3]], mrf[w[2:0]]);
            lat = (w[11:10] == 2'd0) ? 1 : (w[11:10] == 2'd1) ? 2 : 3;
            drive(w[11:10], w[9], w[8:6], w[5:3], w[2:0]);
            step();
            idle();
            n = 1;
            wait_bus(n);
            chk("R3 latency", n, lat + 2);
            chk("R2 tag", cdb_tag, (w[11:10] == 2'd0) ? 1 : (w[11:10] == 2'd1) ? 2 : 4);
            chk("R3 value", cdb_value, e1);
            step();
            mrf[w[8:6]] = e1;
            peek(w[8:6], v, t);
            chk("R7 committed value", v, e1);
            chk("R7 tag cleared", t, 0);
        end

        // R6/R9: dependent floating-point op starts on the broadcast edge
        e1 = 16'(mrf[2] * mrf[3]);
        e2 = e1 + mrf[2];
        drive(2'd3, 1'b0, 3'd1, 3'd2, 3'd3);
        step();
        peek(3'd1, v, t);
        chk("R5 rename tag", t, 4);
        drive(2'd3, 1'b1, 3'd4, 3'd1, 3'd2);
        step();
        idle();
        peek(3'd4, v, t);
        chk("R2 second FP slot", t, 5);
        n = 0;
        wait_bus(n);
        chk("R9 producer tag", cdb_tag, 4);
        chk("R9 producer value", cdb_value, e1);
        step();
        n = 1;
        wait_bus(n);
        chk("R9 start on broadcast edge", n, 4);
        chk("R6 consumer tag", cdb_tag, 5);
        chk("R6 consumer value", cdb_value, e2);
        step();
        mrf[1] = e1;
        mrf[4] = e2;

        // R5/R7: older FP write to r5 finishes after younger integer write
        e1 = 16'(mrf[2] * mrf[3]);
        e2 = mrf[1] + mrf[1];
        drive(2'd3, 1'b0, 3'd5, 3'd2, 3'd3);
        step();
        chk("R5 no stall on WAW", fu_free[0], 1'b1);
        drive(2'd0, 1'b0, 3'd5, 3'd1, 3'd1);
        step();
        idle();
        peek(3'd5, v, t);
        chk("R5 newest producer", t, 1);
        n = 0;
        wait_bus(n);
        chk("R7 young tag", cdb_tag, 1);
        chk("R7 young value", cdb_value, e2);
        step();
        chk("R7 old broadcast", cdb_valid, 1'b1);
        chk("R7 old tag", cdb_tag, 4);
        chk("R7 old value", cdb_value, e1);
        step();
        peek(3'd5, v, t);
        chk("R7 stale result dropped", v, e2);
        chk("R7 tag clear", t, 0);
        mrf[5] = e2;

        // R11: load and integer op finish on the same edge
        e1 = exp_res(2'd1, 1'b0, mrf[0], mrf[1]);
        e2 = mrf[2] + mrf[3];
        drive(2'd1, 1'b0, 3'd6, 3'd0, 3'd1);
        step();
        drive(2'd0, 1'b0, 3'd7, 3'd2, 3'd3);
        step();
        idle();
        n = 0;
        wait_bus(n);
        chk("R11 lowest first", cdb_tag, 1);
        chk("R11 winner value", cdb_value, e2);
        step();
        chk("R11 loser retries", cdb_valid, 1'b1);
        chk("R11 loser tag", cdb_tag, 2);
        chk("R11 loser value", cdb_value, e1);
        step();
        mrf[6] = e1;
        mrf[7] = e2;

        // R10/R6: reuse the broadcasting slot and read its result at dispatch
        e1 = mrf[1] + mrf[2];
        drive(2'd0, 1'b0, 3'd6, 3'd1, 3'd2);
        step();
        idle();
        chk("R4 integer slot full", fu_free[0], 1'b0);
        n = 0;
        wait_bus(n);
        chk("R10 broadcasting tag", cdb_tag, 1);
        chk("R10 free while broadcasting", fu_free[0], 1'b1);
        e2 = e1 + e1;
        drive(2'd0, 1'b0, 3'd7, 3'd6, 3'd6);
        step();
        idle();
        peek(3'd6, v, t);
        chk("R7 commit r6", v, e1);
        peek(3'd7, v, t);
        chk("R10 slot reallocated", t, 1);
        n = 0;
        wait_bus(n);
        chk("R6 dispatch snoop value", cdb_value, e2);
        step();
        mrf[6] = e1;
        mrf[7] = e2;

        // R4: both FP slots busy, third FP dispatch dropped
        e1 = 16'(mrf[1] * mrf[1]);
        e2 = mrf[1] + mrf[2];
        drive(2'd3, 1'b0, 3'd0, 3'd1, 3'd1);
        step();
        drive(2'd3, 1'b1, 3'd3, 3'd1, 3'd2);
        step();
        chk("R4 FP full", fu_free[3], 1'b0);
        drive(2'd3, 1'b0, 3'd2, 3'd1, 3'd1);
        step();
        idle();
        peek(3'd2, v, t);
        chk("R4 dropped no rename", t, 0);
        nb = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            if (cdb_valid) begin
                nb++;
                chk("R4 FP result", cdb_value, (cdb_tag == 3'd4) ? e1 : e2);
            end
        end
        chk("R4 broadcast count", nb, 2);
        peek(3'd2, v, t);
        chk("R4 r2 untouched", v, mrf[2]);
        mrf[0] = e1;
        mrf[3] = e2;

        // R8: store renames nothing, stays off the bus, frees its slot
        drive(2'd2, 1'b0, 3'd3, 3'd1, 3'd2);
        step();
        idle();
        chk("R8 store slot taken", fu_free[2], 1'b0);
        peek(3'd3, v, t);
        chk("R8 no rename", t, 0);
        nb = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (cdb_valid) nb++;
        end
        chk("R8 no broadcast", nb, 0);
        chk("R8 slot freed", fu_free[2], 1'b1);
        peek(3'd3, v, t);
        chk("R8 r3 unchanged", v, mrf[3]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule